// File: doc/BRIEF.md
# Horizontal Edge-Class Sample Adaptive Offset Filter

This block filters one rectangular block of 8-bit samples with the horizontal edge class of sample adaptive offset. Samples enter in raster order, one per accepted cycle, on a valid/ready handshake. Each sample is compared with its left and right neighbours. The comparison gives an edge category. The category is remapped to an offset slot, and boundary columns may be forced to slot 0. The signed offset from the selected slot is added to the sample and the sum is clipped back into the sample range. Filtered samples leave on a second valid/ready handshake, in the order they arrived.

The block width and height are set by configuration inputs. For each row, side inputs supply the sample to the left of column 0 and the sample just past the last column. Two availability flags, each 0x00 or 0xFF, gate the outermost columns. Five signed offsets are supplied.

While the block streams, three side outputs pulse with unfiltered samples for use by the following block:
- the original last column, one pulse per row;
- the original bottom row, one pulse per column;
- the top-left corner value, which is the caller's previous top-row sample at position width-1, sent once per block.

The configuration, flags and offsets must stay constant from the first accepted sample of a block until its last filtered sample has left.

Top module: `sao_hedge_filter`

## Requirements
- R1: While reset is active, and in the first cycle after the synchronised reset is released, `out_valid`, `edge_col_valid`, `bottom_row_valid` and `corner_valid` are 0 and `in_ready` is 1.
- R2: Signs and raw category.
  - Each sign is +1 when the sample is greater than the neighbour, -1 when it is less and 0 when equal, using unsigned comparison.
  - The raw category is 2 + left sign + right sign.
  - The raw category maps to an offset slot as 0→1, 1→2, 2→0, 3→3, 4→4.
  - `offsets[8k+7:8k]` holds the signed offset for slot k.
- R3: The output is the sample plus the selected signed offset, clipped to 0..255.
- R4: Column 0 takes its left neighbour from `row_left`. The last column takes its right neighbour from `row_right`. Both are sampled with the sample accepted in that column.
- R5: In column 0 the slot is ANDed with `avail_left[2:0]`, and in the last column with `avail_right[2:0]`. A flag of 0x00 forces slot 0. With a width of 1, both masks apply.
- R6: Classification uses the original, unfiltered neighbour values.
- R7: Exactly one filtered sample leaves for each accepted sample, in input order. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R8: For each row, one cycle after the last-column sample is accepted, `edge_col_valid` pulses for one cycle with that unfiltered sample.
- R9: For each bottom-row sample, one cycle after it is accepted, `bottom_row_valid` pulses for one cycle with that unfiltered sample.
- R10: One cycle after the first sample of a block is accepted, `corner_valid` pulses for one cycle with `top_prev_last`.
- R11: Back-pressure loses no sample. When the output register is full and not taken while a sample is held, `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_width | input | COL_W | Block width in samples (1 or more) |
| blk_height | input | ROW_W | Block height in rows (1 or more) |
| avail_left | input | 8 | Left edge availability flag, 0x00 or 0xFF |
| avail_right | input | 8 | Right edge availability flag, 0x00 or 0xFF |
| offsets | input | 5*OFF_W | Five signed offsets, slot k in bits [8k+7:8k] |
| top_prev_last | input | PIX_W | Previous top-row sample at position width-1 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | PIX_W | Input sample |
| row_left | input | PIX_W | Left neighbour of column 0 for the current row |
| row_right | input | PIX_W | Right neighbour of the last column for the current row |
| out_valid | output | 1 | Filtered sample valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | PIX_W | Filtered sample |
| edge_col_valid | output | 1 | Last-column sample pulse |
| edge_col_data | output | PIX_W | Unfiltered last-column sample |
| bottom_row_valid | output | 1 | Bottom-row sample pulse |
| bottom_row_data | output | PIX_W | Unfiltered bottom-row sample |
| corner_valid | output | 1 | Corner sample pulse |
| corner_data | output | PIX_W | Corner sample |

## Verification
The assertions check on every cycle that a stalled output holds its value, that input is refused while the pipeline is full and stalled, that a masked boundary column and a flat sample both reach slot 0, and that a corner pulse matches a first-sample acceptance.

Only the bench's scenarios can show the rest: the exact filtered arithmetic with clipping, the remap order, that neighbours are the original values, and that side outputs carry the right samples. It sweeps block sizes, both availability flags and back-pressure patterns, and compares every output against an arithmetic model.

// File: rtl/sao_hedge_pkg.sv
package sao_hedge_pkg;
  localparam int NUM_SLOTS = 5;
  localparam int SLOT_W    = 3;

  typedef logic [SLOT_W-1:0] slot_t;

  // raw edge category (0..4) to offset slot
  function automatic slot_t remap_category(input logic [2:0] raw);
    slot_t s;
    case (raw)
      3'd0:    s = 3'd1;
      3'd1:    s = 3'd2;
      3'd2:    s = 3'd0;
      3'd3:    s = 3'd3;
      3'd4:    s = 3'd4;
      default: s = 3'd0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sao_hedge_scan.sv
module sao_hedge_scan #(
  parameter int COL_W = 8,
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [COL_W-1:0] blk_width,
  input  logic [ROW_W-1:0] blk_height,
  output logic             col_first,
  output logic             col_last,
  output logic             row_last,
  output logic             blk_first
);
  logic [COL_W-1:0] col_q, col_nxt;
  logic [ROW_W-1:0] row_q, row_nxt;

  assign col_first = (col_q == '0);
  assign col_last  = (col_q == blk_width - COL_W'(1));
  assign row_last  = (row_q == blk_height - ROW_W'(1));
  assign blk_first = col_first && (row_q == '0);

  always_comb begin
    col_nxt = col_q;
    row_nxt = row_q;
    if (col_last) begin
      col_nxt = '0;
      row_nxt = row_last ? '0 : row_q + ROW_W'(1);
    end else begin
      col_nxt = col_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (adv) begin
      col_q <= col_nxt;
      row_q <= row_nxt;
    end
  end
endmodule

// File: rtl/sao_hedge_classify.sv
module sao_hedge_classify
  import sao_hedge_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int FLG_W = 8
) (
  input  logic [PIX_W-1:0] cur,
  input  logic [PIX_W-1:0] left_nb,
  input  logic [PIX_W-1:0] right_nb,
  input  logic             at_first,
  input  logic             at_last,
  input  logic [FLG_W-1:0] flag_left,
  input  logic [FLG_W-1:0] flag_right,
  output logic [2:0]       raw_cat,
  output slot_t            slot
);
  logic gt_l, lt_l, gt_r, lt_r;
  slot_t mapped, mask_l, mask_r;

  assign gt_l = cur > left_nb;
  assign lt_l = cur < left_nb;
  assign gt_r = cur > right_nb;
  assign lt_r = cur < right_nb;

  always_comb begin
    raw_cat = 3'(3'd2 + {2'b00, gt_l} + {2'b00, gt_r} - {2'b00, lt_l} - {2'b00, lt_r});
    mapped  = remap_category(raw_cat);
    mask_l  = at_first ? flag_left[SLOT_W-1:0]  : '1;
    mask_r  = at_last  ? flag_right[SLOT_W-1:0] : '1;
    slot    = mapped & mask_l & mask_r;
  end
endmodule

// File: rtl/sao_hedge_apply.sv
module sao_hedge_apply
  import sao_hedge_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int OFF_W = 8
) (
  input  logic [PIX_W-1:0]           cur,
  input  slot_t                      slot,
  input  logic [NUM_SLOTS*OFF_W-1:0] offsets,
  output logic [PIX_W-1:0]           result
);
  localparam int SUM_W = PIX_W + 2;
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((1 << PIX_W) - 1);

  logic [OFF_W-1:0] off_tab [NUM_SLOTS];
  logic [OFF_W-1:0] off_sel;
  logic signed [SUM_W-1:0] sum;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_unpack
    assign off_tab[k] = offsets[k*OFF_W +: OFF_W];
  end

  always_comb begin
    off_sel = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (slot == SLOT_W'(k)) off_sel = off_tab[k];
    end
    sum = $signed({2'b00, cur}) + $signed({{(SUM_W-OFF_W){off_sel[OFF_W-1]}}, off_sel});
    if (sum < 0)          result = '0;
    else if (sum > MAX_V) result = MAX_V[PIX_W-1:0];
    else                  result = sum[PIX_W-1:0];
  end
endmodule

// File: rtl/sao_hedge_filter.sv
module sao_hedge_filter
  import sao_hedge_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int OFF_W = 8,
  parameter int COL_W = 8,
  parameter int ROW_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [COL_W-1:0]           blk_width,
  input  logic [ROW_W-1:0]           blk_height,
  input  logic [7:0]                 avail_left,
  input  logic [7:0]                 avail_right,
  input  logic [NUM_SLOTS*OFF_W-1:0] offsets,
  input  logic [PIX_W-1:0]           top_prev_last,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [PIX_W-1:0]           in_data,
  input  logic [PIX_W-1:0]           row_left,
  input  logic [PIX_W-1:0]           row_right,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [PIX_W-1:0]           out_data,
  output logic                       edge_col_valid,
  output logic [PIX_W-1:0]           edge_col_data,
  output logic                       bottom_row_valid,
  output logic [PIX_W-1:0]           bottom_row_data,
  output logic                       corner_valid,
  output logic [PIX_W-1:0]           corner_data
);
  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // scan position
  logic in_fire, col_first, col_last, row_last, blk_first;
  sao_hedge_scan #(.COL_W(COL_W), .ROW_W(ROW_W)) u_scan (
    .clk, .rst_n(rst_sync_n), .adv(in_fire),
    .blk_width, .blk_height,
    .col_first, .col_last, .row_last, .blk_first
  );

  // held sample (waits for its right neighbour)
  logic             h_valid, h_valid_nxt, h_load;
  logic [PIX_W-1:0] h_cur, h_left, h_rside;
  logic [PIX_W-1:0] h_left_nxt;
  logic             h_first, h_last;
  logic             o_free, finish;
  logic [PIX_W-1:0] nb_right;

  assign o_free   = !out_valid || out_ready;
  assign in_ready = !h_valid || o_free;
  assign in_fire  = in_valid && in_ready;
  assign finish   = h_valid && o_free && (h_last || in_valid);
  assign nb_right = h_last ? h_rside : in_data;

  always_comb begin
    h_load      = in_fire;
    h_left_nxt  = col_first ? row_left : h_cur;
    h_valid_nxt = h_valid;
    if (in_fire)     h_valid_nxt = 1'b1;
    else if (finish) h_valid_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) h_valid <= 1'b0;
    else             h_valid <= h_valid_nxt;
  end

  always_ff @(posedge clk) begin
    if (h_load) begin
      h_cur   <= in_data;
      h_left  <= h_left_nxt;
      h_rside <= row_right;
      h_first <= col_first;
      h_last  <= col_last;
    end
  end

  // classification and offset
  logic [2:0]       cls_raw;
  slot_t            cls_slot;
  logic [PIX_W-1:0] filt;

  sao_hedge_classify #(.PIX_W(PIX_W), .FLG_W(8)) u_cls (
    .cur(h_cur), .left_nb(h_left), .right_nb(nb_right),
    .at_first(h_first), .at_last(h_last),
    .flag_left(avail_left), .flag_right(avail_right),
    .raw_cat(cls_raw), .slot(cls_slot)
  );

  sao_hedge_apply #(.PIX_W(PIX_W), .OFF_W(OFF_W)) u_apply (
    .cur(h_cur), .slot(cls_slot), .offsets, .result(filt)
  );

  // output register
  logic o_valid_nxt;
  always_comb begin
    o_valid_nxt = out_valid;
    if (finish)         o_valid_nxt = 1'b1;
    else if (out_ready) o_valid_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= o_valid_nxt;
  end

  always_ff @(posedge clk) begin
    if (finish) out_data <= filt;
  end

  // unfiltered side outputs for the following block
  logic ec_nxt, br_nxt, cn_nxt;
  always_comb begin
    ec_nxt = in_fire && col_last;
    br_nxt = in_fire && row_last;
    cn_nxt = in_fire && blk_first;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      edge_col_valid   <= 1'b0;
      bottom_row_valid <= 1'b0;
      corner_valid     <= 1'b0;
    end else begin
      edge_col_valid   <= ec_nxt;
      bottom_row_valid <= br_nxt;
      corner_valid     <= cn_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (ec_nxt) edge_col_data   <= in_data;
    if (br_nxt) bottom_row_data <= in_data;
    if (cn_nxt) corner_data     <= top_prev_last;
  end

  // assertions
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (h_valid && out_valid && !out_ready) |-> !in_ready);

  assert_mask_left_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (h_valid && h_first && avail_left[2:0] == 3'd0) |-> (cls_slot == 3'd0));

  assert_mask_right_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (h_valid && h_last && avail_right[2:0] == 3'd0) |-> (cls_slot == 3'd0));

  assert_flat_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (h_valid && h_cur == h_left && h_cur == nb_right) |-> (cls_raw == 3'd2 && cls_slot == 3'd0));

  assert_corner_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    corner_valid |-> $past(in_valid && in_ready));
endmodule

// File: tb/sao_hedge_filter_test.sv
module sao_hedge_filter_test;
  localparam int PIX_W = 8, OFF_W = 8, COL_W = 4, ROW_W = 3;
  localparam int MAXW = 8, MAXH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic [COL_W-1:0] blk_width;
  logic [ROW_W-1:0] blk_height;
  logic [7:0]       avail_left, avail_right;
  logic [5*OFF_W-1:0] offsets;
  logic [PIX_W-1:0] top_prev_last, in_data, row_left, row_right;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [PIX_W-1:0] out_data, edge_col_data, bottom_row_data, corner_data;
  logic edge_col_valid, bottom_row_valid, corner_valid;

  sao_hedge_filter #(.PIX_W(PIX_W), .OFF_W(OFF_W), .COL_W(COL_W), .ROW_W(ROW_W)) uut (
    .clk, .rst_n, .blk_width, .blk_height, .avail_left, .avail_right, .offsets,
    .top_prev_last, .in_valid, .in_ready, .in_data, .row_left, .row_right,
    .out_valid, .out_ready, .out_data, .edge_col_valid, .edge_col_data,
    .bottom_row_valid, .bottom_row_data, .corner_valid, .corner_data
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] pix [MAXH][MAXW];
  logic [7:0] lefts [MAXH], rights [MAXH];
  logic [7:0] exp_out [MAXH*MAXW];
  string      exp_tag [MAXH*MAXW];
  int cur_w = 1, cur_h = 1;
  int n_out, n_edge, n_bot, n_corner;
  logic [7:0] exp_corner;
  bit mon_en = 0, bp = 0;
  logic [15:0] lfsr = 16'hACE1, rd_lfsr = 16'h1D2B;

  function automatic logic [15:0] lstep(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] pick_pix(input logic [15:0] v);
    case (v[2:0])
      3'd0: return 8'd0;
      3'd1: return 8'd1;
      3'd2: return 8'd127;
      3'd3: return 8'd128;
      3'd4: return 8'd129;
      3'd5: return 8'd254;
      3'd6: return 8'd255;
      default: return 8'd128;
    endcase
  endfunction

  function automatic int sgn(input int a, input int b);
    return (a > b) ? 1 : ((a < b) ? -1 : 0);
  endfunction

  // arithmetic reference for one block (R2..R6)
  task automatic build_expect(input int w, input int h, input logic [7:0] fl, input logic [7:0] fr);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        int cur, lnb, rnb, raw, slot, sum, res;
        logic [7:0] ob;
        cur = pix[r][c];
        lnb = (c == 0) ? lefts[r] : pix[r][c-1];
        rnb = (c == w-1) ? rights[r] : pix[r][c+1];
        raw = 2 + sgn(cur, lnb) + sgn(cur, rnb);
        case (raw) 0: slot = 1; 1: slot = 2; 2: slot = 0; 3: slot = 3; default: slot = 4; endcase
        if (c == 0)   slot = slot & int'(fl[2:0]);
        if (c == w-1) slot = slot & int'(fr[2:0]);
        ob  = offsets[slot*8 +: 8];
        sum = cur + int'($signed(ob));
        res = (sum < 0) ? 0 : ((sum > 255) ? 255 : sum);
        exp_out[r*w+c] = 8'(res);
        if (res != sum)      exp_tag[r*w+c] = "R3 clip";
        else if (c == 0)     exp_tag[r*w+c] = "R4 R5 first column";
        else if (c == w-1)   exp_tag[r*w+c] = "R4 R5 last column";
        else                 exp_tag[r*w+c] = "R2 R6 interior";
      end
    end
  endtask

  // monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid && out_ready) begin
        if (n_out < cur_w*cur_h)
          check(out_data == exp_out[n_out], exp_tag[n_out], out_data, exp_out[n_out]);
        else
          check(1'b0, "R7 extra output", n_out, cur_w*cur_h);
        n_out++;
      end
      if (edge_col_valid) begin
        if (n_edge < cur_h)
          check(edge_col_data == pix[n_edge][cur_w-1], "R8 edge column", edge_col_data, pix[n_edge][cur_w-1]);
        n_edge++;
      end
      if (bottom_row_valid) begin
        if (n_bot < cur_w)
          check(bottom_row_data == pix[cur_h-1][n_bot], "R9 bottom row", bottom_row_data, pix[cur_h-1][n_bot]);
        n_bot++;
      end
      if (corner_valid) begin
        check(corner_data == exp_corner, "R10 corner", corner_data, exp_corner);
        n_corner++;
      end
    end
  end

  // consumer ready pattern
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      rd_lfsr = lstep(rd_lfsr);
      out_ready = bp ? (rd_lfsr[0] | rd_lfsr[3]) : 1'b1;
    end
  end

  task automatic run_block(input int w, input int h, input bit fl_on, input bit fr_on, input bit bpm);
    logic [7:0] fl, fr;
    fl = fl_on ? 8'hFF : 8'h00;
    fr = fr_on ? 8'hFF : 8'h00;
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        lfsr = lstep(lfsr); pix[r][c] = pick_pix(lfsr);
      end
      lfsr = lstep(lfsr); lefts[r]  = pick_pix(lfsr);
      lfsr = lstep(lfsr); rights[r] = pick_pix(lfsr);
    end
    for (int k = 0; k < 5; k++) begin
      lfsr = lstep(lfsr); offsets[k*8 +: 8] = lfsr[7:0];
    end
    lfsr = lstep(lfsr); top_prev_last = lfsr[11:4];
    exp_corner  = top_prev_last;
    blk_width   = COL_W'(w);
    blk_height  = ROW_W'(h);
    avail_left  = fl;
    avail_right = fr;
    build_expect(w, h, fl, fr);
    cur_w = w; cur_h = h;
    n_out = 0; n_edge = 0; n_bot = 0; n_corner = 0;
    bp = bpm;
    mon_en = 1;
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        lfsr = lstep(lfsr);
        if (bpm && lfsr[0]) begin
          in_valid = 1'b0;
          @(posedge clk); #1;
        end
        in_valid  = 1'b1;
        in_data   = pix[r][c];
        row_left  = lefts[r];
        row_right = rights[r];
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (n_out >= w*h && n_edge >= h && n_bot >= w && n_corner >= 1) break;
    end
    @(posedge clk); #1;
    bp = 0;
    check(n_out == w*h, bpm ? "R7 R11 output count" : "R7 output count", n_out, w*h);
    check(n_edge == h, "R8 edge column count", n_edge, h);
    check(n_bot == w, "R9 bottom row count", n_bot, w);
    check(n_corner == 1, "R10 corner count", n_corner, 1);
    mon_en = 0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_out, cur_w*cur_h);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; row_left = '0; row_right = '0;
    blk_width = COL_W'(1); blk_height = ROW_W'(1); avail_left = 8'hFF; avail_right = 8'hFF;
    offsets = '0; top_prev_last = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && !edge_col_valid && !bottom_row_valid && !corner_valid,
          "R1 valids low in reset", out_valid, 0);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1 no output after reset", out_valid, 0);
    @(posedge clk); #1;
    for (int w = 1; w <= 6; w++)
      for (int h = 1; h <= 3; h++)
        for (int f = 0; f < 4; f++)
          run_block(w, h, f[0], f[1], ((w + h + f) % 2) == 1);
    run_block(8, 4, 1'b1, 1'b1, 1'b1);
    run_block(8, 4, 1'b0, 1'b0, 1'b0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule